// File: doc/BRIEF.md
# Chained Range Table Walker

This block services a miss in a range translation buffer. It takes one miss at a time: a range identifier and the virtual address that missed. It forms the address of that identifier's entry in a per-context range table and reads the entry as four 64-bit words over a request/response memory port. It then tests the address against the entry's lower and upper bounds. A match installs the entry into the range buffer. A miss on a sub-range that has a successor makes the walker follow the successor identifier and test again. A miss on the final sub-range is reported as a safety violation.

Entries marked as dummy are still installed when they match. In the same cycle the walker also asks the page walker for the real translation of the address. Invalid entries and chains that run longer than a parameterised hop budget end the walk with a fault. The hop budget stops a cyclic chain from hanging the walker. The memory behind the port and the page walker are outside this block.

Top module: `range_chain_walker`

## Requirements
- R1: `miss_ready` is high only while the walker is idle. A miss is taken on a cycle with `miss_valid` and `miss_ready` both high. `miss_id`, `miss_va` and `ctx_table_base` are sampled at that cycle, and later changes to them have no effect on the walk in progress.
- R2: Word k (k = 0..3) of the entry for identifier i is requested at address `ctx_table_base + 32*i + 8*k`, in increasing k. Word 0 is the lower bound, word 1 the upper bound, word 2 the delta and word 3 the control word. The request address holds steady while `mem_req_ready` is low.
- R3: In the control word, bit 0 is valid, bit 1 is dummy, bit 2 marks the last sub-range, and bits [8 +: ID_W] give the successor identifier.
- R4: An address is inside an entry when lower <= address < upper, compared as unsigned values. On a match the walker pulses `fill_valid` with that entry's bounds, delta and dummy flag. `fill_id` is the identifier of the original miss.
- R5: When the matching entry is a dummy, `ptw_req_valid` pulses with `ptw_req_va` equal to the missed address in the same cycle as the fill.
- R6: When the address is outside a valid entry whose last flag is clear, the walker fetches the entry named by the successor identifier and tests it in the same way.
- R7: When the address is outside a valid entry whose last flag is set, the walker reports fault code 0 (bounds violation) and makes no fill.
- R8: An entry whose valid bit is clear ends the walk with fault code 1 and no fill.
- R9: If MAX_HOPS entries have been fetched without reaching a result, the walk ends with fault code 2 and no fill.
- R10: Every walk ends with a single-cycle `done_valid` pulse. In that cycle exactly one of `fill_valid` or `fault_valid` is high, and `miss_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | Walker is idle and will take a miss |
| miss_id | input | ID_W | Range identifier of the miss |
| miss_va | input | 64 | Virtual address that missed |
| ctx_table_base | input | 64 | Range table base of the current context |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the word requested |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done_valid | output | 1 | Walk finished (one-cycle pulse) |
| fill_valid | output | 1 | Install the entry in the range buffer |
| fill_id | output | ID_W | Identifier under which to install |
| fill_base | output | 64 | Lower bound of the installed entry |
| fill_limit | output | 64 | Upper bound (exclusive) of the installed entry |
| fill_delta | output | 64 | Translation delta of the installed entry |
| fill_dummy | output | 1 | Installed entry is a dummy |
| ptw_req_valid | output | 1 | Page-table lookup request |
| ptw_req_va | output | 64 | Address for the page-table lookup |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 0 bounds violation, 1 invalid entry, 2 hop limit |

## Verification
On every cycle, the in-RTL assertions check the following. A request address stays stable under back-pressure. Idle never overlaps an outstanding request. Each completion carries exactly one of fill or fault, and a page-table request comes only with a dummy fill. The hop counter never passes its budget. Only the bench scenarios can show that the walk follows the right chain: the address arithmetic, the bound comparison at its edges, the choice between violation, invalid and hop-limit faults, and the fact that inputs changed mid-walk are ignored. The bench shows these by sweeping every table identifier against addresses at and around each bound, with and without memory stalls, and with two table bases.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
    localparam int WORD_W      = 64;
    localparam int ENTRY_WORDS = 4;
    localparam int ENTRY_SHIFT = 5;
    localparam int CTL_VALID   = 0;
    localparam int CTL_DUMMY   = 1;
    localparam int CTL_LAST    = 2;
    localparam int CTL_NEXT_LO = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_CHECK
    } walk_state_e;

    typedef enum logic [2:0] {
        VD_FILL,
        VD_NEXT,
        VD_F_BOUNDS,
        VD_F_INVALID,
        VD_F_HOPS
    } verdict_e;

    typedef enum logic [1:0] {
        FLT_BOUNDS  = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_HOPS    = 2'd2
    } fault_e;

    typedef struct packed {
        logic valid;
        logic dummy;
        logic last;
    } ctl_flags_t;

    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] delta;
        ctl_flags_t        flags;
    } entry_t;

    function automatic logic addr_inside(input logic [WORD_W-1:0] va,
                                         input logic [WORD_W-1:0] lo,
                                         input logic [WORD_W-1:0] hi);
        return (va >= lo) && (va < hi);
    endfunction

    function automatic ctl_flags_t decode_flags(input logic [WORD_W-1:0] w);
        ctl_flags_t f;
        f.valid = w[CTL_VALID];
        f.dummy = w[CTL_DUMMY];
        f.last  = w[CTL_LAST];
        return f;
    endfunction
endpackage

// File: rtl/rwalk_addr_gen.sv
module rwalk_addr_gen
    import rwalk_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic [WORD_W-1:0] table_base,
    input  logic [ID_W-1:0]   cur_id,
    input  logic [1:0]        word_idx,
    output logic [WORD_W-1:0] addr
);
    localparam int WORD_BYTES_LOG = 3;

    logic [WORD_W-1:0] entry_off;
    logic [WORD_W-1:0] word_off;

    always_comb begin
        entry_off = WORD_W'(cur_id) << ENTRY_SHIFT;
        word_off  = WORD_W'(word_idx) << WORD_BYTES_LOG;
        addr      = table_base + entry_off + word_off;
    end
endmodule

// File: rtl/rwalk_entry_buf.sv
module rwalk_entry_buf
    import rwalk_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [1:0]        word_idx,
    input  logic [WORD_W-1:0] data,
    output entry_t            entry,
    output logic [ID_W-1:0]   next_id
);
    localparam int DATA_WORDS = ENTRY_WORDS - 1;

    logic [WORD_W-1:0] words_q [DATA_WORDS];
    ctl_flags_t        flags_q;
    logic [ID_W-1:0]   next_q;

    for (genvar g = 0; g < DATA_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[g] <= '0;
            end else if (load && word_idx == 2'(g)) begin
                words_q[g] <= data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            next_q  <= '0;
        end else if (load && word_idx == 2'(DATA_WORDS)) begin
            flags_q <= decode_flags(data);
            next_q  <= data[CTL_NEXT_LO +: ID_W];
        end
    end

    always_comb begin
        entry.lo    = words_q[0];
        entry.hi    = words_q[1];
        entry.delta = words_q[2];
        entry.flags = flags_q;
        next_id     = next_q;
    end
endmodule

// File: rtl/rwalk_decide.sv
module rwalk_decide
    import rwalk_pkg::*;
#(
    parameter int MAX_HOPS = 8,
    localparam int HOP_W   = $clog2(MAX_HOPS + 1)
) (
    input  logic [WORD_W-1:0] va,
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  ctl_flags_t        flags,
    input  logic [HOP_W-1:0]  hops,
    output verdict_e          verdict
);
    always_comb begin
        if (!flags.valid) begin
            verdict = VD_F_INVALID;
        end else if (addr_inside(va, lo, hi)) begin
            verdict = VD_FILL;
        end else if (flags.last) begin
            verdict = VD_F_BOUNDS;
        end else if (hops >= HOP_W'(MAX_HOPS)) begin
            verdict = VD_F_HOPS;
        end else begin
            verdict = VD_NEXT;
        end
    end
endmodule

// File: rtl/range_chain_walker.sv
module range_chain_walker
    import rwalk_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int MAX_HOPS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ID_W-1:0]   miss_id,
    input  logic [63:0]       miss_va,
    input  logic [63:0]       ctx_table_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              done_valid,
    output logic              fill_valid,
    output logic [ID_W-1:0]   fill_id,
    output logic [63:0]       fill_base,
    output logic [63:0]       fill_limit,
    output logic [63:0]       fill_delta,
    output logic              fill_dummy,
    output logic              ptw_req_valid,
    output logic [63:0]       ptw_req_va,
    output logic              fault_valid,
    output logic [1:0]        fault_code
);
    localparam int HOP_W     = $clog2(MAX_HOPS + 1);
    localparam int LAST_WORD = ENTRY_WORDS - 1;

    walk_state_e       state_q;
    logic [ID_W-1:0]   orig_id_q;
    logic [ID_W-1:0]   cur_id_q;
    logic [63:0]       va_q;
    logic [63:0]       tbase_q;
    logic [1:0]        word_q;
    logic [HOP_W-1:0]  hops_q;

    logic              done_q, fill_q, fault_q, ptw_q, dummy_q;
    logic [63:0]       base_o_q, limit_o_q, delta_o_q;
    logic [1:0]        code_q;

    entry_t            entry;
    logic [ID_W-1:0]   next_id;
    verdict_e          verdict;
    logic              load_word;

    assign load_word = (state_q == ST_WAIT) && mem_rsp_valid;

    rwalk_addr_gen #(.ID_W(ID_W)) u_addr (
        .table_base (tbase_q),
        .cur_id     (cur_id_q),
        .word_idx   (word_q),
        .addr       (mem_req_addr)
    );

    rwalk_entry_buf #(.ID_W(ID_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .load     (load_word),
        .word_idx (word_q),
        .data     (mem_rsp_data),
        .entry    (entry),
        .next_id  (next_id)
    );

    rwalk_decide #(.MAX_HOPS(MAX_HOPS)) u_decide (
        .va      (va_q),
        .lo      (entry.lo),
        .hi      (entry.hi),
        .flags   (entry.flags),
        .hops    (hops_q),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            orig_id_q <= '0;
            cur_id_q  <= '0;
            va_q      <= '0;
            tbase_q   <= '0;
            word_q    <= '0;
            hops_q    <= '0;
            done_q    <= 1'b0;
            fill_q    <= 1'b0;
            fault_q   <= 1'b0;
            ptw_q     <= 1'b0;
            dummy_q   <= 1'b0;
            base_o_q  <= '0;
            limit_o_q <= '0;
            delta_o_q <= '0;
            code_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            fill_q  <= 1'b0;
            fault_q <= 1'b0;
            ptw_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        orig_id_q <= miss_id;
                        cur_id_q  <= miss_id;
                        va_q      <= miss_va;
                        tbase_q   <= ctx_table_base;
                        word_q    <= '0;
                        hops_q    <= '0;
                        state_q   <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (word_q == 2'(LAST_WORD)) begin
                            hops_q  <= hops_q + 1'b1;
                            state_q <= ST_CHECK;
                        end else begin
                            word_q  <= word_q + 1'b1;
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_CHECK: begin
                    case (verdict)
                        VD_FILL: begin
                            fill_q    <= 1'b1;
                            ptw_q     <= entry.flags.dummy;
                            dummy_q   <= entry.flags.dummy;
                            base_o_q  <= entry.lo;
                            limit_o_q <= entry.hi;
                            delta_o_q <= entry.delta;
                            done_q    <= 1'b1;
                            state_q   <= ST_IDLE;
                        end
                        VD_NEXT: begin
                            cur_id_q <= next_id;
                            word_q   <= '0;
                            state_q  <= ST_REQ;
                        end
                        VD_F_BOUNDS: begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_BOUNDS;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        VD_F_INVALID: begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_INVALID;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        default: begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_HOPS;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign miss_ready    = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_REQ);
    assign done_valid    = done_q;
    assign fill_valid    = fill_q;
    assign fill_id       = orig_id_q;
    assign fill_base     = base_o_q;
    assign fill_limit    = limit_o_q;
    assign fill_delta    = delta_o_q;
    assign fill_dummy    = dummy_q;
    assign ptw_req_valid = ptw_q;
    assign ptw_req_va    = va_q;
    assign fault_valid   = fault_q;
    assign fault_code    = code_q;

    // R1
    idle_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !miss_ready);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5
    ptw_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        ptw_req_valid |-> (fill_valid && fill_dummy));

    // R9
    hop_bound_chk: assert property (@(posedge clk) disable iff (rst)
        hops_q <= HOP_W'(MAX_HOPS));

    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> ($onehot({fill_valid, fault_valid}) && miss_ready));

    // R10
    no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid || fault_valid) |-> done_valid);
endmodule

// File: tb/range_chain_walker_bench.sv
module range_chain_walker_bench;
    localparam int ID_W     = 4;
    localparam int MAX_HOPS = 4;
    localparam int N_ENT    = 16;
    localparam int N_VA     = 18;

    logic              clk = 1'b0;
    logic              rst;
    logic              miss_valid;
    logic              miss_ready;
    logic [ID_W-1:0]   miss_id;
    logic [63:0]       miss_va;
    logic [63:0]       ctx_table_base;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [63:0]       mem_req_addr;
    logic              mem_rsp_valid;
    logic [63:0]       mem_rsp_data;
    logic              done_valid, fill_valid, fill_dummy, ptw_req_valid, fault_valid;
    logic [ID_W-1:0]   fill_id;
    logic [63:0]       fill_base, fill_limit, fill_delta, ptw_req_va;
    logic [1:0]        fault_code;

    always #2.5 clk = ~clk;

    range_chain_walker #(.ID_W(ID_W), .MAX_HOPS(MAX_HOPS)) u_range_chain_walker (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_id(miss_id), .miss_va(miss_va),
        .ctx_table_base(ctx_table_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .fill_valid(fill_valid), .fill_id(fill_id),
        .fill_base(fill_base), .fill_limit(fill_limit), .fill_delta(fill_delta),
        .fill_dummy(fill_dummy), .ptw_req_valid(ptw_req_valid), .ptw_req_va(ptw_req_va),
        .fault_valid(fault_valid), .fault_code(fault_code)
    );

    logic [63:0] t_lo [N_ENT];
    logic [63:0] t_hi [N_ENT];
    logic [63:0] t_dl [N_ENT];
    logic [63:0] t_ct [N_ENT];
    logic [63:0] va_list [N_VA];

    int          checks = 0;
    int          errors = 0;
    int          fetches;
    int          stall_ctr = 0;
    bit          stall_en;
    bit          addr_bad;
    bit          pending;
    logic [63:0] paddr;
    logic [63:0] tb_base;

    function automatic logic [63:0] mk_ctl(bit v, bit d, bit l, int nxt);
        logic [63:0] w;
        w = '0;
        w[0] = v;
        w[1] = d;
        w[2] = l;
        w[8 +: ID_W] = ID_W'(nxt);
        return w;
    endfunction

    task automatic set_ent(int i, logic [63:0] lo, logic [63:0] hi, bit d, bit l, int nxt);
        t_lo[i] = lo;
        t_hi[i] = hi;
        t_dl[i] = 64'h4_0000 + 64'(i) * 64'h1_0000;
        t_ct[i] = mk_ctl(1'b1, d, l, nxt);
    endtask

    function automatic logic [63:0] mem_read(logic [63:0] a);
        logic [63:0] off;
        off = a - tb_base;
        if (off >= 64'(N_ENT * 32) || a[2:0] != 3'b0) begin
            addr_bad = 1'b1;
            return 64'hDEAD_BEEF_DEAD_BEEF;
        end
        case (off[4:3])
            2'd0:    return t_lo[off[63:5]];
            2'd1:    return t_hi[off[63:5]];
            2'd2:    return t_dl[off[63:5]];
            default: return t_ct[off[63:5]];
        endcase
    endfunction

    // memory model with optional back-pressure
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mem_req_ready = 1'b1;
        pending       = 1'b0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_read(paddr);
                pending       = 1'b0;
            end
            stall_ctr++;
            mem_req_ready = !(stall_en && (stall_ctr % 3 == 0));
            if (!rst && mem_req_valid && mem_req_ready) begin
                pending = 1'b1;
                paddr   = mem_req_addr;
                fetches++;
            end
        end
    end

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // kind: 0 fill, 1 bounds, 2 invalid, 3 hop limit
    task automatic model(int id, logic [63:0] va, output int kind, output int hit, output int nf);
        int cur;
        cur  = id;
        nf   = 0;
        hit  = 0;
        kind = 3;
        for (int h = 0; h < MAX_HOPS; h++) begin
            nf++;
            if (!t_ct[cur][0]) begin kind = 2; return; end
            if (va >= t_lo[cur] && va < t_hi[cur]) begin kind = 0; hit = cur; return; end
            if (t_ct[cur][2]) begin kind = 1; return; end
            cur = int'(t_ct[cur][8 +: ID_W]);
        end
    endtask

    task automatic run_miss(int id, logic [63:0] va);
        int  kind, hit, nf, cyc;
        bit  busy_ready;
        model(id, va, kind, hit, nf);
        @(negedge clk);
        miss_valid     = 1'b1;
        miss_id        = ID_W'(id);
        miss_va        = va;
        ctx_table_base = tb_base;
        fetches        = 0;
        addr_bad       = 1'b0;
        busy_ready     = 1'b0;
        @(negedge clk);
        // R1: new values offered during the walk must be ignored
        miss_id        = ~ID_W'(id);
        miss_va        = ~va;
        ctx_table_base = 64'h0123_4000_0000_0000;
        cyc = 0;
        while (!done_valid && cyc < 400) begin
            if (miss_ready) busy_ready = 1'b1;
            @(negedge clk);
            cyc++;
        end
        miss_valid = 1'b0;
        if (cyc >= 400) begin
            check(1'b0, "R10", "walk timeout", 64'(cyc), 64'd400);
            return;
        end
        check(!busy_ready, "R1", "ready high during walk", 64'(busy_ready), 64'd0);
        check(miss_ready, "R10", "ready at done", 64'(miss_ready), 64'd1);
        check(!addr_bad, "R2", "entry address", paddr, tb_base);
        check(fetches == 4 * nf, "R6", "word fetches", 64'(fetches), 64'(4 * nf));
        check(fill_valid == (kind == 0), "R4", "fill_valid", 64'(fill_valid), 64'(kind == 0));
        check(fault_valid == (kind != 0), "R7", "fault_valid", 64'(fault_valid), 64'(kind != 0));
        if (kind == 0) begin
            check(fill_id == ID_W'(id), "R4", "fill_id", 64'(fill_id), 64'(id));
            check(fill_base == t_lo[hit] && fill_limit == t_hi[hit], "R4", "fill bounds",
                  fill_base, t_lo[hit]);
            check(fill_delta == t_dl[hit], "R4", "fill_delta", fill_delta, t_dl[hit]);
            check(fill_dummy == t_ct[hit][1], "R3", "fill_dummy", 64'(fill_dummy), 64'(t_ct[hit][1]));
            check(ptw_req_valid == t_ct[hit][1], "R5", "ptw_req_valid",
                  64'(ptw_req_valid), 64'(t_ct[hit][1]));
            if (t_ct[hit][1])
                check(ptw_req_va == va, "R5", "ptw_req_va", ptw_req_va, va);
        end else begin
            check(!ptw_req_valid, "R5", "ptw on fault", 64'(ptw_req_valid), 64'd0);
            if (kind == 1)
                check(fault_code == 2'd0, "R7", "fault_code", 64'(fault_code), 64'd0);
            else if (kind == 2)
                check(fault_code == 2'd1, "R8", "fault_code", 64'(fault_code), 64'd1);
            else
                check(fault_code == 2'd2, "R9", "fault_code", 64'(fault_code), 64'd2);
        end
        @(negedge clk);
        check(!done_valid, "R10", "done pulse width", 64'(done_valid), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_ENT; i++) begin
            t_lo[i] = '0; t_hi[i] = '0; t_dl[i] = '0; t_ct[i] = '0;
        end
        set_ent(0, 64'h1000, 64'h2000, 1'b0, 1'b1, 0);
        set_ent(1, 64'h1000, 64'h2000, 1'b0, 1'b0, 2);
        set_ent(2, 64'h3000, 64'h4000, 1'b1, 1'b0, 3);
        set_ent(3, 64'h5000, 64'h6000, 1'b0, 1'b1, 0);
        set_ent(5, 64'h0000, 64'h0100, 1'b0, 1'b0, 4);
        set_ent(6, 64'h0100, 64'h0200, 1'b0, 1'b0, 7);
        set_ent(7, 64'h0300, 64'h0400, 1'b0, 1'b0, 6);
        set_ent(8, 64'h8000, 64'h9000, 1'b1, 1'b1, 0);
        va_list = '{64'h0, 64'h50, 64'hFF, 64'h100, 64'h350, 64'hFFF, 64'h1000, 64'h1FFF,
                    64'h2000, 64'h2FFF, 64'h3000, 64'h3FFF, 64'h4000, 64'h5000, 64'h5FFF,
                    64'h6000, 64'h8FFF, 64'h9000};

        rst = 1'b1; miss_valid = 1'b0; miss_id = '0; miss_va = '0;
        ctx_table_base = '0; stall_en = 1'b0; tb_base = 64'h1_0000;
        repeat (3) @(negedge clk);
        check(miss_ready, "R1", "reset ready", 64'(miss_ready), 64'd1);
        check(!mem_req_valid, "R2", "reset req", 64'(mem_req_valid), 64'd0);
        check(!done_valid && !fill_valid && !fault_valid, "R10", "reset results",
              64'({done_valid, fill_valid, fault_valid}), 64'd0);
        rst = 1'b0;

        for (int pass = 0; pass < 2; pass++) begin
            stall_en = (pass == 1);
            tb_base  = (pass == 0) ? 64'h1_0000 : 64'h0000_8000_0000_0020;
            for (int id = 0; id < 9; id++)
                for (int v = 0; v < N_VA; v++)
                    run_miss(id, va_list[v]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule